// File: doc/BRIEF.md
# Status-Register Flash Command Sequencer

This block runs single operations on a parallel NOR flash that reports progress through a status register. A host raises a one-cycle request with an operation code, a word address and, for a program, a data word. The sequencer then writes the command words on a simple synchronous flash bus. Where the operation needs it, it reads back the word or the protection state. It polls the status register until the device reports ready or a cycle budget runs out, and it always hands the device back in read-array mode. It finishes with a single `done` pulse and a two-bit result code.

The sequencer protects the array and the host in three ways. A program that would need any bit to go from 0 to 1 is refused before any bus write. A poll that exceeds the budget suspends the device instead of waiting forever. A lock or unlock is confirmed by reading the protection state back, so the host never takes the request as proof that the change happened.

Top module: `nfs_cmd_seq`

## Requirements
- R1: Op code 0 (program) first reads the target word. If the word is erased enough, the block writes 0x50, then 0xFF, then 0x40, then the raw data word to the target address, in consecutive cycles.
- R2: If (target word AND data) differs from data, a program ends with result 2 and makes no bus write at all.
- R3: The device is ready when bit 7 of every 16-bit lane reads 1. A ready status with bit 4 set in any lane after a program gives result 1. Otherwise a ready status gives result 0.
- R4: If ready has not been seen within TMO_CYC cycles of polling, the block writes the suspend command 0xB0 and then reports result 1.
- R5: Every operation other than a refused program ends with a write of 0x50 and then 0xFF to the operation address, and `done` follows the 0xFF write in the next cycle.
- R6: Op code 1 (sector erase) writes 0x50, 0x20 and 0xD0 to the sector address and then polls as in R3. Bit 5 set in any lane of the ready status gives result 1.
- R7: Op code 2 (lock) writes 0x60 then 0x01, and op code 3 (unlock) writes 0x60 then 0xD0, to the sector address. Either one then writes 0x90 and reads the word at sector address + 2.
- R8: In that read, bit 0 of each lane marks the lane as protected. All lanes set means locked and none means unlocked. A mixed pattern counts as locked and gives result 1, and a state that differs from the request gives result 1.
- R9: `busy` is high from the cycle after a request is accepted through the `done` cycle. A request raised while `busy` is high is ignored.
- R10: A command word carries the command byte in bits [7:0] of every 16-bit lane, with zeros in bits [15:8] of each lane.
- R11: After reset `busy`, `done` and `fl_we` are low. `done` is a one-cycle pulse. `result` is 0 (success), 1 (failure or timeout) or 2 (not erased), and never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 program, 1 erase, 2 lock, 3 unlock |
| req_addr | input | ADDR_W | Target word or sector address |
| req_data | input | DATA_W | Program data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, valid with done |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_rdata | input | DATA_W | Flash read data, one cycle after a non-write address |

## Verification
A wrong sequencer state shows at the ports almost at once, because each state puts a fixed command on the bus. A skipped or repeated step shows up as a wrong or missing write in the very cycle it happens. A wrong decision after a read shows within a few cycles, as the wrong next write or as a wrong result code with `done`. A stuck or wrongly cleared timeout counter shows only as a missing suspend write, or as a suspend that comes too early, in a hang scenario. The protection verdict shows only in the result code, so the mixed and stuck-lock cases are driven on purpose.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_ERASE  = 2'd1,
      OP_LOCK   = 2'd2,
      OP_UNLOCK = 2'd3
   } nfs_op_e;

   localparam logic [1:0] RES_OK         = 2'd0;
   localparam logic [1:0] RES_FAIL       = 2'd1;
   localparam logic [1:0] RES_NOT_ERASED = 2'd2;

   localparam logic [7:0] CB_CLR_STAT  = 8'h50;
   localparam logic [7:0] CB_READ_ARR  = 8'hFF;
   localparam logic [7:0] CB_PROG_SET  = 8'h40;
   localparam logic [7:0] CB_ERASE_SET = 8'h20;
   localparam logic [7:0] CB_CONFIRM   = 8'hD0;
   localparam logic [7:0] CB_PROT_SET  = 8'h60;
   localparam logic [7:0] CB_PROT_ON   = 8'h01;
   localparam logic [7:0] CB_SUSPEND   = 8'hB0;
   localparam logic [7:0] CB_READ_ID   = 8'h90;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHK_A,
      ST_CHK_S,
      ST_W_CLR,
      ST_W_RD,
      ST_W_SETUP,
      ST_W_DATA,
      ST_POLL_A,
      ST_POLL_S,
      ST_SUSP,
      ST_VER_ID,
      ST_VER_A,
      ST_VER_S,
      ST_END_CLR,
      ST_END_RD,
      ST_DONE
   } nfs_state_e;

endpackage

// File: rtl/nfs_lane_rep.sv
module nfs_lane_rep #(
   parameter int DATA_W = 32
) (
   input  logic [7:0]        cmd_byte,
   output logic [DATA_W-1:0] cmd_word
);
   localparam int LANES = DATA_W / 16;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign cmd_word[16*g +: 16] = {8'h00, cmd_byte};
   end

endmodule

// File: rtl/nfs_status_eval.sv
module nfs_status_eval #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] prog_word,
   output logic              ready,
   output logic              err_prog,
   output logic              err_erase,
   output logic              prot_all,
   output logic              prot_any,
   output logic              not_erased
);
   localparam int LANES = DATA_W / 16;

   logic [LANES-1:0] rdy_l, ep_l, ee_l, pr_l;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdy_l[g] = rd_word[16*g + 7];
      assign ep_l[g]  = rd_word[16*g + 4];
      assign ee_l[g]  = rd_word[16*g + 5];
      assign pr_l[g]  = rd_word[16*g];
   end

   assign ready      = &rdy_l;
   assign err_prog   = |ep_l;
   assign err_erase  = |ee_l;
   assign prot_all   = &pr_l;
   assign prot_any   = |pr_l;
   assign not_erased = (rd_word & prog_word) != prog_word;

endmodule

// File: rtl/nfs_timer.sv
module nfs_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign expired = cnt >= CW'(LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (run && !expired) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/nfs_cmd_seq.sv
module nfs_cmd_seq
   import nfs_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 20,
   parameter int TMO_CYC = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   output logic              fl_we,
   input  logic [DATA_W-1:0] fl_rdata
);
   if (DATA_W != 16 && DATA_W != 32) begin : g_bad_width
      $error("nfs_cmd_seq: DATA_W must be 16 or 32");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("nfs_cmd_seq: ADDR_W must be at least 2");
   end
   if (TMO_CYC < 1) begin : g_bad_tmo
      $error("nfs_cmd_seq: TMO_CYC must be positive");
   end

   nfs_state_e        st, st_nx;
   nfs_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [1:0]        res_q, res_nx;
   logic [7:0]        cmd_byte;
   logic [DATA_W-1:0] cmd_word;
   logic              accept;
   logic              s_ready, s_err_p, s_err_e, s_all, s_any, s_not_erased;
   logic              tmo;

   assign accept = (st == ST_IDLE) && req_valid;

   nfs_lane_rep #(.DATA_W(DATA_W)) u_rep (
      .cmd_byte (cmd_byte),
      .cmd_word (cmd_word)
   );

   nfs_status_eval #(.DATA_W(DATA_W)) u_eval (
      .rd_word    (fl_rdata),
      .prog_word  (data_q),
      .ready      (s_ready),
      .err_prog   (s_err_p),
      .err_erase  (s_err_e),
      .prot_all   (s_all),
      .prot_any   (s_any),
      .not_erased (s_not_erased)
   );

   nfs_timer #(.LIMIT(TMO_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .run     (st == ST_POLL_A || st == ST_POLL_S),
      .expired (tmo)
   );

   always_comb begin
      st_nx  = st;
      res_nx = res_q;
      unique case (st)
         ST_IDLE: begin
            if (req_valid) begin
               res_nx = RES_OK;
               unique case (nfs_op_e'(req_op))
                  OP_PROG:  st_nx = ST_CHK_A;
                  OP_ERASE: st_nx = ST_W_CLR;
                  default:  st_nx = ST_W_SETUP;
               endcase
            end
         end
         ST_CHK_A: st_nx = ST_CHK_S;
         ST_CHK_S: begin
            if (s_not_erased) begin
               res_nx = RES_NOT_ERASED;
               st_nx  = ST_DONE;
            end else begin
               st_nx = ST_W_CLR;
            end
         end
         ST_W_CLR:   st_nx = (op_q == OP_PROG) ? ST_W_RD : ST_W_SETUP;
         ST_W_RD:    st_nx = ST_W_SETUP;
         ST_W_SETUP: st_nx = ST_W_DATA;
         ST_W_DATA:  st_nx = (op_q == OP_LOCK || op_q == OP_UNLOCK) ? ST_VER_ID : ST_POLL_A;
         ST_POLL_A:  st_nx = ST_POLL_S;
         ST_POLL_S: begin
            if (s_ready) begin
               if ((op_q == OP_PROG && s_err_p) || (op_q == OP_ERASE && s_err_e)) begin
                  res_nx = RES_FAIL;
               end
               st_nx = ST_END_CLR;
            end else if (tmo) begin
               res_nx = RES_FAIL;
               st_nx  = ST_SUSP;
            end else begin
               st_nx = ST_POLL_A;
            end
         end
         ST_SUSP:   st_nx = ST_END_CLR;
         ST_VER_ID: st_nx = ST_VER_A;
         ST_VER_A:  st_nx = ST_VER_S;
         ST_VER_S: begin
            if ((s_any && !s_all) || (s_any != (op_q == OP_LOCK))) begin
               res_nx = RES_FAIL;
            end
            st_nx = ST_END_CLR;
         end
         ST_END_CLR: st_nx = ST_END_RD;
         ST_END_RD:  st_nx = ST_DONE;
         ST_DONE:    st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         res_q  <= RES_OK;
      end else begin
         st    <= st_nx;
         res_q <= res_nx;
         if (accept) begin
            op_q   <= nfs_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
         end
      end
   end

   always_comb begin
      unique case (st)
         ST_W_CLR, ST_END_CLR: cmd_byte = CB_CLR_STAT;
         ST_W_RD, ST_END_RD:   cmd_byte = CB_READ_ARR;
         ST_W_SETUP: begin
            unique case (op_q)
               OP_PROG:  cmd_byte = CB_PROG_SET;
               OP_ERASE: cmd_byte = CB_ERASE_SET;
               default:  cmd_byte = CB_PROT_SET;
            endcase
         end
         ST_W_DATA: cmd_byte = (op_q == OP_LOCK) ? CB_PROT_ON : CB_CONFIRM;
         ST_SUSP:   cmd_byte = CB_SUSPEND;
         ST_VER_ID: cmd_byte = CB_READ_ID;
         default:   cmd_byte = 8'h00;
      endcase
   end

   always_comb begin
      unique case (st)
         ST_W_CLR, ST_W_RD, ST_W_SETUP, ST_W_DATA, ST_SUSP,
         ST_VER_ID, ST_END_CLR, ST_END_RD: fl_we = 1'b1;
         default:                          fl_we = 1'b0;
      endcase
   end

   assign fl_wdata = (st == ST_W_DATA && op_q == OP_PROG) ? data_q : cmd_word;
   assign fl_addr  = (st == ST_VER_A || st == ST_VER_S) ? addr_q + ADDR_W'(2) : addr_q;
   assign busy     = (st != ST_IDLE);
   assign done     = (st == ST_DONE);
   assign result   = res_q;

endmodule

// File: rtl/nfs_seq_chk.sv
module nfs_seq_chk
   import nfs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [1:0]        result,
   input logic              fl_we,
   input logic [DATA_W-1:0] fl_wdata,
   input nfs_state_e        st
);
   localparam int LANES = DATA_W / 16;
   localparam logic [DATA_W-1:0] W_CLR = {LANES{8'h00, CB_CLR_STAT}};
   localparam logic [DATA_W-1:0] W_RD  = {LANES{8'h00, CB_READ_ARR}};

   // R11: completion is a single-cycle pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: no bus write while idle
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fl_we);

   // R11: reserved code never reported
   a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result != 2'd3);

   // R9: done only inside a busy window
   a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R5: read-array command right before completion
   a_r5_ends_read_array: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result != RES_NOT_ERASED) |-> ($past(fl_we) && $past(fl_wdata) == W_RD));

   // R2: refused program leaves the bus untouched just before done
   a_r2_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RES_NOT_ERASED) |-> !$past(fl_we));

   // R4: suspend is followed by clear-status
   a_r4_suspend_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SUSP) |=> (fl_we && fl_wdata == W_CLR));

endmodule

bind nfs_cmd_seq nfs_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .result   (result),
   .fl_we    (fl_we),
   .fl_wdata (fl_wdata),
   .st       (st)
);

// File: tb/nfs_cmd_seq_tb.sv
module nfs_cmd_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 32;
   localparam int AW  = 12;
   localparam int TMO = 40;
   localparam int LAT = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          busy, done, fl_we;
   logic [1:0]    result;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata;
   logic [DW-1:0] fl_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   nfs_cmd_seq #(.DATA_W(DW), .ADDR_W(AW), .TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .result(result), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
      .fl_rdata(fl_rdata)
   );

   int total = 0;
   int bad   = 0;
   int done_cnt = 0;
   string cur_tag = "R11";
   logic [1:0] exp_res = 2'd0;
   logic [AW+DW-1:0] exp_q[$];
   logic [AW+DW-1:0] got, want;

   function automatic logic [DW-1:0] cw(input logic [7:0] b);
      return {8'h00, b, 8'h00, b};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // ---------------- behavioural flash ----------------
   typedef enum int {M_ARR, M_STAT, M_ID} fmode_e;
   fmode_e mode;
   int pend;          // 0 none, 1 program, 2 erase, 3 protect
   int bcnt;
   logic [7:0] sr_err;
   logic [DW-1:0] mem [16];
   logic [1:0] lk [16];
   bit inj_err = 0, inj_hang = 0, inj_mixed = 0, inj_stuck = 0;
   logic [7:0] c;
   logic [3:0] ix, ixm;

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i] = '1;
         lk[i]  = 2'b00;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mode <= M_ARR; pend <= 0; bcnt <= 0; sr_err <= 8'h00; fl_rdata <= '0;
      end else begin
         if (bcnt > 0) bcnt <= bcnt - 1;
         c  = fl_wdata[7:0];
         ix = fl_addr[3:0];
         ixm = ix - 4'd2;
         if (fl_we) begin
            if (pend == 1) begin
               mem[ix] <= mem[ix] & fl_wdata; pend <= 0; mode <= M_STAT;
               bcnt <= inj_hang ? 100000 : LAT;
               if (inj_err) sr_err <= 8'h10;
            end else if (pend == 2) begin
               pend <= 0;
               if (c == 8'hD0) begin
                  mem[ix] <= '1; mode <= M_STAT;
                  bcnt <= inj_hang ? 100000 : LAT;
                  if (inj_err) sr_err <= 8'h20;
               end
            end else if (pend == 3) begin
               pend <= 0; mode <= M_STAT;
               if (!inj_stuck) begin
                  if (c == 8'h01) lk[ix] <= inj_mixed ? 2'b01 : 2'b11;
                  else if (c == 8'hD0) lk[ix] <= 2'b00;
               end
            end else begin
               case (c)
                  8'h50: sr_err <= 8'h00;
                  8'hFF: mode <= M_ARR;
                  8'h40: pend <= 1;
                  8'h20: pend <= 2;
                  8'h60: pend <= 3;
                  8'h90: mode <= M_ID;
                  8'hB0: mode <= M_STAT;
                  default: ;
               endcase
            end
         end else begin
            case (mode)
               M_ARR:  fl_rdata <= mem[ix];
               M_STAT: fl_rdata <= (bcnt > 0) ? '0 : {8'h00, 8'h80 | sr_err, 8'h00, 8'h80 | sr_err};
               default: fl_rdata <= {15'h0, lk[ixm][1], 15'h0, lk[ixm][0]};
            endcase
         end
      end
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         if (fl_we) begin
            got = {fl_addr, fl_wdata};
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected write"}, 64'(got), 64'(0));
            end else begin
               want = exp_q.pop_front();
               chk(got == want, {cur_tag, " bus write"}, 64'(got), 64'(want));
            end
         end
         if (done) begin
            done_cnt++;
            chk(result == exp_res, {cur_tag, " result"}, 64'(result), 64'(exp_res));
            chk(exp_q.size() == 0, {cur_tag, " writes left"}, 64'(exp_q.size()), 64'(0));
         end
      end
   end

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] eres, input string tag, input bit intrude);
      int start;
      cur_tag = tag;
      exp_res = eres;
      case (op)
         2'd0: if (eres != 2'd2) begin
                  push(a, cw(8'h50)); push(a, cw(8'hFF)); push(a, cw(8'h40)); push(a, d);
                  if (inj_hang) push(a, cw(8'hB0));
                  push(a, cw(8'h50)); push(a, cw(8'hFF));
               end
         2'd1: begin
                  push(a, cw(8'h50)); push(a, cw(8'h20)); push(a, cw(8'hD0));
                  if (inj_hang) push(a, cw(8'hB0));
                  push(a, cw(8'h50)); push(a, cw(8'hFF));
               end
         2'd2: begin
                  push(a, cw(8'h60)); push(a, cw(8'h01)); push(a, cw(8'h90));
                  push(a, cw(8'h50)); push(a, cw(8'hFF));
               end
         default: begin
                  push(a, cw(8'h60)); push(a, cw(8'hD0)); push(a, cw(8'h90));
                  push(a, cw(8'h50)); push(a, cw(8'hFF));
               end
      endcase
      start = done_cnt;
      @(posedge clk); #1;
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (intrude) begin
         repeat (3) @(posedge clk);
         #1;
         req_valid = 1'b1; req_op = 2'd1; req_addr = a; req_data = '0;
         @(posedge clk); #1;
         req_valid = 1'b0;
      end
      for (int i = 0; i < 2000 && done_cnt == start; i++) @(posedge clk);
      chk(done_cnt == start + 1, {tag, " completion"}, 64'(done_cnt - start), 64'(1));
      @(posedge clk); #1;
      inj_err = 0; inj_hang = 0; inj_mixed = 0; inj_stuck = 0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fl_we, "R11 reset state", 64'({busy, done, fl_we}), 64'(0));

      // R1 R10 program on erased word, then a subset program
      run_op(2'd0, 12'h003, 32'h1234_5678, 2'd0, "R1 R10 R3 program", 0);
      run_op(2'd0, 12'h003, 32'h1234_5670, 2'd0, "R1 subset program", 0);
      // R2 needs 0->1
      run_op(2'd0, 12'h003, 32'h0000_0001, 2'd2, "R2 not erased", 0);
      // R3 program error bit
      inj_err = 1;
      run_op(2'd0, 12'h004, 32'hA5A5_0F0F, 2'd1, "R3 program error", 0);
      // R4 timeout and suspend
      inj_hang = 1;
      run_op(2'd0, 12'h005, 32'h0F0F_0F0F, 2'd1, "R4 timeout", 0);
      // R6 erase then program a 0->1 pattern on the erased word
      run_op(2'd1, 12'h003, '0, 2'd0, "R6 R5 erase", 0);
      run_op(2'd0, 12'h003, 32'h0000_0001, 2'd0, "R6 erased word accepts", 0);
      inj_err = 1;
      run_op(2'd1, 12'h006, '0, 2'd1, "R6 erase error", 0);
      inj_hang = 1;
      run_op(2'd1, 12'h007, '0, 2'd1, "R4 erase timeout", 0);
      // R7 R8 protection
      run_op(2'd2, 12'h008, '0, 2'd0, "R7 R8 lock", 0);
      run_op(2'd3, 12'h008, '0, 2'd0, "R7 R8 unlock", 0);
      inj_mixed = 1;
      run_op(2'd2, 12'h009, '0, 2'd1, "R8 mixed lanes", 0);
      run_op(2'd3, 12'h009, '0, 2'd0, "R8 unlock after mixed", 0);
      inj_stuck = 1;
      run_op(2'd2, 12'h009, '0, 2'd1, "R8 lock not taken", 0);
      run_op(2'd2, 12'h00A, '0, 2'd0, "R8 lock for stuck unlock", 0);
      inj_stuck = 1;
      run_op(2'd3, 12'h00A, '0, 2'd1, "R8 unlock not taken", 0);
      // R9 request while busy is ignored
      run_op(2'd0, 12'h001, 32'h00FF_00FF, 2'd0, "R9 busy program", 1);
      repeat (30) @(posedge clk);
      run_op(2'd0, 12'h001, 32'h0F00_0000, 2'd2, "R9 ignored erase left word", 0);
      repeat (5) @(negedge clk);
      chk(!busy && !fl_we, "R11 idle at end", 64'({busy, fl_we}), 64'(0));
      finish_run();
   end

endmodule